// File: doc/BRIEF.md
# I2C Target with High-Speed Mode Entry

This block is the bus-side half of a small I2C target. It oversamples SCL and SDA with the system clock and finds START, repeated START and STOP conditions. It then runs the byte protocol: it matches a 7-bit device address, takes written bytes into an 8-bit configuration register, and shifts out read bytes from a parallel buffer supplied by the surrounding logic. SDA is never driven high. The block only asserts an output enable that pulls the open-drain line low.

A first byte of the form `00001xxx` after a START is the master code that announces high-speed transfers. The block leaves that byte unacknowledged and raises `hs_mode`, which a filter or timing block can use. `hs_mode` stays set through repeated STARTs and drops at the next STOP. A read ends cleanly when the master leaves the ninth pulse high. The block then stays off the bus until the next START or STOP.

Top module: `i2c_hs_target`

## Requirements
- R1: After reset, `sda_oe` is 0, `hs_mode` is 0 and `cfg_q` is 0x00.
- R2: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged: SDA is held low for the whole high phase of the ninth pulse. Bit 0 of that byte selects a write (0) or a read (1).
- R3: An address byte that does not match gets no acknowledge. The block then drives nothing until the next START or STOP, and any bytes that follow leave `cfg_q` unchanged.
- R4: In a write, each data byte is acknowledged. It appears on `cfg_q` by the end of its ninth pulse.
- R5: In a read, bytes go out MSB first, starting with `rd_buf[7:0]`, then `rd_buf[15:8]`, and so on. The sequence wraps to the first byte after byte `RD_BYTES-1`. SDA is released during every ninth pulse.
- R6: If the master does not acknowledge a read byte (SDA high on the ninth pulse), the block drives nothing until the next START or STOP.
- R7: A first byte matching `00001xxx` after a START is not acknowledged and sets `hs_mode`.
- R8: `hs_mode` stays set across a repeated START and clears on the next STOP.
- R9: START and STOP are recognised only while SCL is high. A repeated START in the middle of a transfer restarts address reception.
- R10: `sda_oe` changes only after a detected SCL falling edge or a START/STOP. It is 0 while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| rd_buf | input | 8*RD_BYTES | Read data; byte 0 in bits 7:0 |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_q | output | 8 | Last byte written by the master |
| hs_mode | output | 1 | High-speed mode flag |

## Verification
Each bus edge passes through two synchronizer flops and one edge register, so every reaction is registered about three system clocks after the SCL or SDA change that causes it. The bench holds each SCL phase for 16 clocks. It reads SDA in the middle of the high phase, well after the target's drive has settled. `cfg_q` is checked only after the ninth pulse has finished. `hs_mode` is checked once the code byte, the repeated START or the STOP has completed, each of which is more than three clocks past the triggering edge.

// File: rtl/i2c_hs_target.sv
module i2c_hs_target #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int RD_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic [RD_BYTES*8-1:0]   rd_buf,
  output logic                    sda_oe,
  output logic [7:0]              cfg_q,
  output logic                    hs_mode
);
  localparam int IW = (RD_BYTES > 1) ? $clog2(RD_BYTES) : 1;
  localparam logic [IW-1:0] LAST = IW'(RD_BYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_RD, S_SKIP} st_t;

  logic [2:0] scl_p, sda_p;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, tx, cur_byte;
  logic [IW-1:0] idx;
  logic       dir;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl_s = scl_p[1], scl_d = scl_p[2];
  wire sda_s = sda_p[1], sda_d = sda_p[2];
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire is_hs    = (sh[7:3] == 5'b00001);
  wire is_me    = (sh[7:1] == DEV_ADDR);

  always_comb begin
    cur_byte = '0;
    for (int i = 0; i < RD_BYTES; i++)
      if (idx == IW'(i)) cur_byte = rd_buf[i*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; idx <= '0;
      dir <= 1'b0; sda_oe <= 1'b0; cfg_q <= '0; hs_mode <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; sda_oe <= 1'b0; hs_mode <= 1'b0;
    end else if (start_c) begin
      st <= S_ADDR; cnt <= '0; idx <= '0; sda_oe <= 1'b0;
    end else if (st != S_IDLE && st != S_SKIP) begin
      if (scl_rise) begin
        if (cnt < 4'd8) sh <= {sh[6:0], sda_s};
        if (cnt < 4'd9) cnt <= cnt + 4'd1;
        if (cnt == 4'd8 && st == S_RD && sda_s) st <= S_SKIP;
      end else if (scl_fall) begin
        if (cnt >= 4'd1 && cnt <= 4'd7) begin
          if (st == S_RD) sda_oe <= ~tx[3'd7 - cnt[2:0]];
        end else if (cnt == 4'd8) begin
          case (st)
            S_ADDR:
              if (is_hs) begin
                hs_mode <= 1'b1; st <= S_SKIP; sda_oe <= 1'b0;
              end else if (is_me) begin
                dir <= sh[0]; sda_oe <= 1'b1;
              end else begin
                st <= S_SKIP; sda_oe <= 1'b0;
              end
            S_WR: begin cfg_q <= sh; sda_oe <= 1'b1; end
            default: sda_oe <= 1'b0;
          endcase
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          if ((st == S_ADDR && dir) || st == S_RD) begin
            st     <= S_RD;
            tx     <= cur_byte;
            sda_oe <= ~cur_byte[7];
            idx    <= (idx == LAST) ? '0 : idx + IW'(1);
          end else begin
            if (st == S_ADDR) st <= S_WR;
            sda_oe <= 1'b0;
          end
        end
      end
    end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!sda_oe && !hs_mode && cfg_q == 8'h00));

  a_r5_ack_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && cnt == 4'd9) |-> !sda_oe);

  a_r6_skip_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !sda_oe);

  a_r7_hs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> ($past(st) == S_ADDR && $past(cnt) == 4'd8 && !sda_oe));

  a_r8_hs_clear_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !hs_mode);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  a_r10_oe_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_c) || $past(stop_c)));
endmodule

// File: tb/i2c_hs_target_test.sv
`timescale 1ns/1ps
module i2c_hs_target_test;
  localparam int H = 16;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, hs_mode;
  logic [7:0] cfg_q;
  logic [23:0] rd_buf = 24'h7E_81_C3;
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_hs_target #(.DEV_ADDR(7'h68), .RD_BYTES(3)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .rd_buf(rd_buf), .sda_oe(sda_oe), .cfg_q(cfg_q), .hs_mode(hs_mode));

  // fields: addr byte [24:17], data [16:9], hit [8], expected cfg [7:0]
  localparam logic [24:0] VEC [6] = '{
    {8'hD0, 8'h5A, 1'b1, 8'h5A},
    {8'hD0, 8'hA5, 1'b1, 8'hA5},
    {8'h44, 8'h33, 1'b0, 8'hA5},
    {8'hD0, 8'hFF, 1'b1, 8'hFF},
    {8'hD2, 8'h00, 1'b0, 8'hFF},
    {8'hD0, 8'h00, 1'b1, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic m_start;
    sda_m = 1'b1; tick(H); scl = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl = 1'b0; tick(H);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; tick(H); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; tick(H); scl = 1'b1; tick(H/2);
    r = sda_line; tick(H/2); scl = 1'b0; tick(4);
  endtask

  task automatic m_write(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, ack);
  endtask

  task automatic m_read(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      d[i] = r;
    end
    m_bit(mack, r);
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 hs_mode", hs_mode, 0);
    check("R1 cfg_q", cfg_q, 0);

    for (int v = 0; v < 6; v++) begin
      m_start;
      m_write(VEC[v][24:17], a);
      check(VEC[v][8] ? "R2 address ack" : "R3 mismatch no ack", a, !VEC[v][8]);
      m_write(VEC[v][16:9], a);
      check(VEC[v][8] ? "R4 data ack" : "R3 ignored data", a, !VEC[v][8]);
      check(VEC[v][8] ? "R4 cfg stored" : "R3 cfg unchanged", cfg_q, VEC[v][7:0]);
      m_stop;
      tick(4);
      check("R10 idle released", sda_oe, 0);
    end

    // R5 and R6: read with wrap, then master NACK
    m_start;
    m_write(8'hD1, a);
    check("R2 read address ack", a, 0);
    m_read(1'b0, d); check("R5 byte0", d, 8'hC3);
    m_read(1'b0, d); check("R5 byte1", d, 8'h81);
    m_read(1'b0, d); check("R5 byte2", d, 8'h7E);
    m_read(1'b1, d); check("R5 wrap to byte0", d, 8'hC3);
    m_read(1'b1, d); check("R6 released after NACK", d, 8'hFF);
    m_stop;

    // R9: repeated START after a write address restarts address reception
    m_start;
    m_write(8'hD0, a);
    check("R9 first address ack", a, 0);
    m_start;
    m_write(8'hD1, a);
    check("R9 restart address ack", a, 0);
    m_read(1'b1, d); check("R9 read after restart", d, 8'hC3);
    m_stop;

    // R7 and R8: high-speed master code
    m_start;
    m_write(8'h09, a);
    check("R7 code not acked", a, 1);
    check("R7 hs_mode set", hs_mode, 1);
    m_start;
    check("R8 hs_mode kept over repeated START", hs_mode, 1);
    m_write(8'hD0, a);
    check("R8 address ack in hs mode", a, 0);
    m_write(8'h3C, a);
    check("R8 data ack in hs mode", a, 0);
    check("R4 cfg in hs mode", cfg_q, 8'h3C);
    check("R8 hs_mode still set", hs_mode, 1);
    m_stop;
    tick(4);
    check("R8 hs_mode cleared by STOP", hs_mode, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule